// File: doc/BRIEF.md
# Execution Breakpoint and Debug Exception Unit

This unit compares every instruction fetch address against a programmable breakpoint address under a programmable bit mask. The comparison is gated by a debug control word. A fetch counts only when the execute enable pair is set in that word. It also needs the enable bit for the half of the address space that the fetch address lies in. On a hit the unit records the event in the two lowest bits of the control word.

When the control word's exception enable is also set, the unit raises a breakpoint exception. It rewrites the cause word, pushes the status word's interrupt/mode stack up by one level, and computes the exception return address. It also redirects the program counter to a fixed debug vector.

A combinational flush strobe is raised in the cycle of the check. Pending-load logic can use it to retire its delayed writes before the new PC takes effect one clock later. The unit also decodes the load and store breakpoint enables for a data address. No data-side matching is performed.

Top module: `dbg_brk_unit`

## Requirements
- R1: An execute hit requires control bits 23 and 24 both set; if either is clear, no hit is recorded and no exception is taken.
- R2: The half-space enable is control bit 30 for addresses with bit 31 clear and control bit 29 for addresses with bit 31 set; the selected bit must be 1 for any hit or data enable.
- R3: The address matches when ((fetch_pc XOR bp_addr) AND bp_mask) is zero; a zero mask matches any address.
- R4: On a strobed check, dctl_out takes dctl_in with bits 1:0 forced to 1 on a hit, or dctl_in unchanged otherwise, one clock after the strobe.
- R5: The exception is taken only on a hit with control bit 31 set. take_now is high combinationally in the strobe cycle; taken_o is high for exactly the following cycle.
- R6: When taken, cause_out keeps only cause_in bits 9:8, has bit 30 equal to in_delay_slot, and has code 9 in bits 6:2; all other bits are zero. When not taken, cause_out equals cause_in.
- R7: When taken, status_out bits 5:2 equal status_in bits 3:0, bits 1:0 are zero, and bits 31:6 are unchanged. When not taken, status_out equals status_in.
- R8: When taken, epc_out is fetch_pc minus 4 if in_delay_slot is 1, else fetch_pc, and pc_out is 0x80000040. When not taken, pc_out equals fetch_pc and epc_out keeps its previous value.
- R9: ld_armed is 1 when control bits 23, 25 and 26 are all set and the half-space bit for data_addr is set. st_armed is 1 when bits 23, 25 and 27 are all set and that half-space bit is set. Both are combinational.
- R10: Without a strobe, all registered outputs hold their values and taken_o is 0.
- R11: After reset, all registered outputs and taken_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check strobe for the current fetch |
| fetch_pc | input | 32 | Fetch address under test |
| in_delay_slot | input | 1 | Fetch is in a branch delay slot |
| dctl_in | input | 32 | Current debug control word |
| bp_addr | input | 32 | Breakpoint address |
| bp_mask | input | 32 | Breakpoint compare mask |
| cause_in | input | 32 | Current cause word |
| status_in | input | 32 | Current status word |
| data_addr | input | 32 | Data address for the load/store enable decode |
| take_now | output | 1 | Combinational: exception is taken this cycle (flush strobe) |
| ld_armed | output | 1 | Load breakpoint enabled for data_addr |
| st_armed | output | 1 | Store breakpoint enabled for data_addr |
| taken_o | output | 1 | One-cycle flag: exception taken at the last strobe |
| dctl_out | output | 32 | Updated debug control word |
| cause_out | output | 32 | Updated cause word |
| status_out | output | 32 | Updated status word |
| epc_out | output | 32 | Exception return address |
| pc_out | output | 32 | Next program counter |

## Verification
take_now, ld_armed and st_armed are combinational. The bench checks them 1 time unit after it drives inputs on the falling edge, within the same cycle. All registered results and taken_o are due at the first rising edge after the strobe. The bench checks them on the following falling edge, before it drives the next stimulus, so each result is tied to exactly one check. Hold behaviour is checked one full cycle after a non-strobed input change, with the reference model left untouched.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int unsigned XW = 32;
  localparam logic [XW-1:0] EXEC_NEED = 32'h0180_0000;
  localparam logic [XW-1:0] LOAD_NEED = 32'h0680_0000;
  localparam logic [XW-1:0] STOR_NEED = 32'h0a80_0000;
  localparam logic [XW-1:0] CAUSE_KEEP = 32'h0000_0300;
  localparam logic [4:0] BP_CODE = 5'd9;
  localparam int unsigned DLY_BIT = 30;
  localparam int unsigned STK_W = 6;

  function automatic logic half_ok(input logic [XW-1:0] dc, input logic [XW-1:0] a);
    return a[XW-1] ? dc[29] : dc[30];
  endfunction

  function automatic logic armed(input logic [XW-1:0] dc, input logic [XW-1:0] a,
                                 input logic [XW-1:0] need);
    return ((dc & need) == need) && half_ok(dc, a);
  endfunction

  function automatic logic addr_hit(input logic [XW-1:0] pc, input logic [XW-1:0] bpa,
                                    input logic [XW-1:0] msk);
    return ((pc ^ bpa) & msk) == '0;
  endfunction

  function automatic logic [XW-1:0] cause_on_bp(input logic [XW-1:0] c, input logic dly);
    logic [XW-1:0] r;
    r = c & CAUSE_KEEP;
    r[DLY_BIT] = dly;
    r[6:2] = BP_CODE;
    return r;
  endfunction

  function automatic logic [XW-1:0] status_on_bp(input logic [XW-1:0] s);
    return {s[XW-1:STK_W], s[STK_W-3:0], 2'b00};
  endfunction

  function automatic logic [XW-1:0] epc_on_bp(input logic [XW-1:0] pc, input logic dly);
    return dly ? pc - XW'(4) : pc;
  endfunction
endpackage

// File: rtl/dbg_brk_exec_cmp.sv
module dbg_brk_exec_cmp
  import dbg_brk_pkg::*;
(
  input  logic [XW-1:0] pc,
  input  logic [XW-1:0] dctl,
  input  logic [XW-1:0] bpa,
  input  logic [XW-1:0] bpm,
  output logic          armed_x,
  output logic          hit
);
  always_comb begin
    armed_x = armed(dctl, pc, EXEC_NEED);
    hit     = armed_x && addr_hit(pc, bpa, bpm);
  end
endmodule

// File: rtl/dbg_brk_data_arm.sv
module dbg_brk_data_arm
  import dbg_brk_pkg::*;
#(
  parameter logic [XW-1:0] NEED = LOAD_NEED
) (
  input  logic [XW-1:0] dctl,
  input  logic [XW-1:0] addr,
  output logic          en
);
  always_comb en = armed(dctl, addr, NEED);
endmodule

// File: rtl/dbg_brk_exc_reg.sv
module dbg_brk_exc_reg
  import dbg_brk_pkg::*;
#(
  parameter logic [XW-1:0] VEC_PC = 32'h8000_0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          hit,
  input  logic          take,
  input  logic [XW-1:0] fetch_pc,
  input  logic          dly,
  input  logic [XW-1:0] dctl_in,
  input  logic [XW-1:0] cause_in,
  input  logic [XW-1:0] status_in,
  output logic          taken_o,
  output logic [XW-1:0] dctl_out,
  output logic [XW-1:0] cause_out,
  output logic [XW-1:0] status_out,
  output logic [XW-1:0] epc_out,
  output logic [XW-1:0] pc_out
);
  logic [XW-1:0] dctl_nx, cause_nx, status_nx, epc_nx, pc_nx;

  always_comb begin
    dctl_nx   = hit ? (dctl_in | XW'(3)) : dctl_in;
    cause_nx  = take ? cause_on_bp(cause_in, dly) : cause_in;
    status_nx = take ? status_on_bp(status_in) : status_in;
    epc_nx    = take ? epc_on_bp(fetch_pc, dly) : epc_out;
    pc_nx     = take ? VEC_PC : fetch_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o    <= 1'b0;
      dctl_out   <= '0;
      cause_out  <= '0;
      status_out <= '0;
      epc_out    <= '0;
      pc_out     <= '0;
    end else begin
      taken_o <= valid && take;
      if (valid) begin
        dctl_out   <= dctl_nx;
        cause_out  <= cause_nx;
        status_out <= status_nx;
        epc_out    <= epc_nx;
        pc_out     <= pc_nx;
      end
    end
  end

  // R5: a taken flag follows a strobed exception request
  p_taken_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(valid) && $past(take));
  // R8: redirect lands on the vector
  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> pc_out == VEC_PC);
  // R7: status stack moved up two places
  p_stack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && take) |=> status_out[1:0] == 2'b00 && status_out[5:2] == $past(status_in[3:0]));
  // R6: exception code written into the cause word
  p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> cause_out[6:2] == BP_CODE);
  // R10: no strobe, nothing moves
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(dctl_out) && $stable(pc_out) && $stable(epc_out) && !taken_o);
  // R4: a hit always leaves both record bits set
  p_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit) |=> dctl_out[1:0] == 2'b11);
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter logic [31:0] VEC_PC = 32'h8000_0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_valid,
  input  logic [31:0] fetch_pc,
  input  logic        in_delay_slot,
  input  logic [31:0] dctl_in,
  input  logic [31:0] bp_addr,
  input  logic [31:0] bp_mask,
  input  logic [31:0] cause_in,
  input  logic [31:0] status_in,
  input  logic [31:0] data_addr,
  output logic        take_now,
  output logic        ld_armed,
  output logic        st_armed,
  output logic        taken_o,
  output logic [31:0] dctl_out,
  output logic [31:0] cause_out,
  output logic [31:0] status_out,
  output logic [31:0] epc_out,
  output logic [31:0] pc_out
);
  localparam int unsigned N_DATA = 2;
  localparam logic [N_DATA*XW-1:0] DATA_NEEDS = {STOR_NEED, LOAD_NEED};

  logic exec_armed, exec_hit;
  logic [N_DATA-1:0] data_en;

  dbg_brk_exec_cmp u_cmp (
    .pc(fetch_pc), .dctl(dctl_in), .bpa(bp_addr), .bpm(bp_mask),
    .armed_x(exec_armed), .hit(exec_hit)
  );

  for (genvar g = 0; g < N_DATA; g++) begin : g_data
    dbg_brk_data_arm #(.NEED(DATA_NEEDS[g*XW +: XW])) u_arm (
      .dctl(dctl_in), .addr(data_addr), .en(data_en[g])
    );
  end

  assign ld_armed = data_en[0];
  assign st_armed = data_en[1];
  assign take_now = chk_valid && exec_hit && dctl_in[31];

  dbg_brk_exc_reg #(.VEC_PC(VEC_PC)) u_exc (
    .clk(clk), .rst_n(rst_n), .valid(chk_valid), .hit(exec_hit), .take(take_now),
    .fetch_pc(fetch_pc), .dly(in_delay_slot), .dctl_in(dctl_in),
    .cause_in(cause_in), .status_in(status_in), .taken_o(taken_o),
    .dctl_out(dctl_out), .cause_out(cause_out), .status_out(status_out),
    .epc_out(epc_out), .pc_out(pc_out)
  );

  // R1: a hit implies the execute enable pair
  p_exec_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exec_hit |-> dctl_in[23] && dctl_in[24]);
  // R5: exception only with the enable bit set
  p_take_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |-> dctl_in[31] && chk_valid);
  // R2: the half-space bit gates every hit
  p_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_hit |-> (fetch_pc[31] ? dctl_in[29] : dctl_in[30]));
  // R9: store enable needs the shared data-side bits
  p_st_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_armed |-> dctl_in[23] && dctl_in[25] && dctl_in[27]);
endmodule

// File: tb/dbg_brk_unit_test.sv
module dbg_brk_unit_test;
  localparam int PERIOD = 10;
  localparam logic [31:0] VEC = 32'h8000_0040;

  logic clk = 0, rst_n = 0, chk_valid = 0, in_delay_slot = 0;
  logic [31:0] fetch_pc = 0, dctl_in = 0, bp_addr = 0, bp_mask = 0;
  logic [31:0] cause_in = 0, status_in = 0, data_addr = 0;
  logic take_now, ld_armed, st_armed, taken_o;
  logic [31:0] dctl_out, cause_out, status_out, epc_out, pc_out;

  int checks = 0, errors = 0;
  logic [31:0] e_dctl = 0, e_cause = 0, e_stat = 0, e_epc = 0, e_pc = 0;
  logic e_taken = 0;

  always #(PERIOD/2) clk = ~clk;

  dbg_brk_unit uut (.*);

  function automatic bit tb_half(logic [31:0] dc, logic [31:0] a);
    int idx = a[31] ? 29 : 30;
    return dc[idx];
  endfunction
  function automatic bit tb_exec(logic [31:0] dc, logic [31:0] pc, logic [31:0] ba, logic [31:0] m);
    bit same = 1;
    for (int i = 0; i < 32; i++) if (m[i] && (pc[i] != ba[i])) same = 0;
    return dc[23] && dc[24] && tb_half(dc, pc) && same;
  endfunction
  function automatic bit tb_ld(logic [31:0] dc, logic [31:0] a);
    return dc[23] && dc[25] && dc[26] && tb_half(dc, a);
  endfunction
  function automatic bit tb_st(logic [31:0] dc, logic [31:0] a);
    return dc[23] && dc[25] && dc[27] && tb_half(dc, a);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] pc, logic dly, logic [31:0] dc,
                      logic [31:0] ba, logic [31:0] m, logic [31:0] c, logic [31:0] s,
                      logic [31:0] da);
    bit hit, tk;
    @(negedge clk);
    chk_valid = v; fetch_pc = pc; in_delay_slot = dly; dctl_in = dc;
    bp_addr = ba; bp_mask = m; cause_in = c; status_in = s; data_addr = da;
    hit = tb_exec(dc, pc, ba, m);
    tk = v && hit && dc[31];
    #1;
    chk("R5 take_now", {31'b0, take_now}, {31'b0, tk});
    chk("R9 ld_armed", {31'b0, ld_armed}, {31'b0, tb_ld(dc, da)});
    chk("R9 st_armed", {31'b0, st_armed}, {31'b0, tb_st(dc, da)});
    e_taken = tk;
    if (v) begin
      e_dctl = hit ? {dc[31:2], 2'b11} : dc;
      if (tk) begin
        e_cause = 32'h0000_0024 | (c & 32'h300) | (dly ? 32'h4000_0000 : 0);
        e_stat = (s & 32'hffff_ffc0) | ((s & 32'hf) << 2);
        e_epc = dly ? pc - 4 : pc;
        e_pc = VEC;
      end else begin
        e_cause = c; e_stat = s; e_pc = pc;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk("R4 dctl_out", dctl_out, e_dctl);
    chk("R5 taken_o", {31'b0, taken_o}, {31'b0, e_taken});
    chk("R6 cause_out", cause_out, e_cause);
    chk("R7 status_out", status_out, e_stat);
    chk("R8 epc_out", epc_out, e_epc);
    chk("R8 pc_out", pc_out, e_pc);
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset dctl", dctl_out, 0);
    chk("R11 reset pc", pc_out, 0);
    chk("R11 reset taken", {31'b0, taken_o}, 0);
    rst_n = 1;
    // R1: only bit 23 of the pair -> no hit
    step(1, 32'h0000_1000, 0, 32'hc080_0000, 32'h0000_1000, 32'hffff_ffff, 32'h300, 32'h3f, 0);
    // R1/R5: full arm, low half, taken
    step(1, 32'h0000_1000, 0, 32'hc180_0000, 32'h0000_1000, 32'hffff_ffff, 32'hffff_ffff, 32'h0000_ff0f, 0);
    // R2: high address with only bit 30 -> no hit
    step(1, 32'h8000_2000, 0, 32'hc180_0000, 32'h8000_2000, 32'hffff_ffff, 32'h1, 32'h5, 0);
    // R2/R8: high address with bit 29, delay slot
    step(1, 32'h8000_2000, 1, 32'ha180_0000, 32'h8000_2000, 32'hffff_ffff, 32'h200, 32'h5, 0);
    // R3: zero mask matches anything; bit 31 clear -> record only
    step(1, 32'h1234_5678, 0, 32'h4180_0000, 32'hdead_beef, 32'h0, 32'h7, 32'h9, 0);
    // R3: one masked differing bit -> miss
    step(1, 32'h0000_0010, 0, 32'hc180_0000, 32'h0000_0000, 32'h0000_0010, 32'h7, 32'h9, 0);
    // R10: no strobe, inputs that would hit
    step(0, 32'h0000_0000, 0, 32'hc180_0000, 32'h0, 32'h0, 32'hffff, 32'hffff, 0);
    // R9: load/store decode both halves
    step(0, 0, 0, 32'h4e80_0000, 0, 0, 0, 0, 32'h0000_0100);
    step(0, 0, 0, 32'h4e80_0000, 0, 0, 0, 0, 32'h8000_0100);
    step(0, 0, 0, 32'h2a80_0000, 0, 0, 0, 0, 32'h8000_0100);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc, dc, m, ba;
      pc = $urandom; m = $urandom;
      dc = $urandom;
      if ($urandom % 4 != 0) dc |= 32'h0180_0000;
      if ($urandom % 3 != 0) dc |= 32'h6000_0000;
      ba = ($urandom % 2) ? (pc ^ ($urandom & ~m)) : $urandom;
      step(($urandom % 5) != 0, pc, $urandom % 2, dc, ba, m, $urandom, $urandom, $urandom);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule